// File: doc/BRIEF.md
# Split-Halfword Branch-and-Link Unit

This unit executes the two halves of a legacy compressed-ISA branch-with-link that is encoded as two separate 16-bit halfwords. The first (prefix) halfword deposits the upper part of a signed offset into the link register, relative to the pipeline PC. The second (suffix) halfword then branches to that partial address plus a low offset and writes the return address back into the link register. One suffix form stays in the compressed instruction set. The other aligns the target to a word and requests a switch to the 32-bit instruction set. An illegal variant of that second form is flagged as undefined.

Each halfword is presented with a one-cycle `in_valid` strobe, together with the pipeline PC and the current link register value. The pipeline PC is the address of the halfword plus 4. All results come out of registers one cycle later. A two-state machine tracks whether the last valid halfword was a prefix: `ST_IDLE` means no prefix is pending, and `ST_PREFIX_SEEN` means one is. A prefix moves the machine to `ST_PREFIX_SEEN`. Any other valid halfword returns it to `ST_IDLE`. A cycle without `in_valid` holds the state. Reset enters `ST_IDLE`. A broken pairing raises `unpred`. Either a suffix arrives in `ST_IDLE`, or something other than a suffix arrives in `ST_PREFIX_SEEN`.

Top module: `split_branch_link`

## Requirements
- R1: A halfword with bits [15:11] = 11110 (prefix) produces `lr_we`=1 and `lr_out` = pc + (sign-extended bits [10:0] shifted left by 12), with `br_taken`=0 and `isa_switch`=0.
- R2: A halfword with bits [15:11] = 11111 produces `br_taken`=1 and `br_target` = lr_in + (zero-extended bits [10:0] shifted left by 1), with `isa_switch`=0.
- R3: A halfword with bits [15:11] = 11101 and bit [0] = 0 produces `br_taken`=1, `isa_switch`=1 and `br_target` = (lr_in with bits [1:0] cleared) + (zero-extended bits [10:1] shifted left by 2).
- R4: A halfword with bits [15:11] = 11101 and bit [0] = 1 produces `undef`=1, with `br_taken`=0, `lr_we`=0 and `isa_switch`=0.
- R5: The 11111 form writes `lr_out` = (pc - 2) with bit 0 set to 1. The 11101/op=0 form writes `lr_out` = pc - 2. Both use the `lr_in` value presented with that halfword, and both assert `lr_we`.
- R6: A suffix halfword (11111 or 11101) that does not immediately follow a valid prefix raises `unpred`=1, and it still executes as in R2 to R5.
- R7: A valid halfword that follows a prefix and is not a suffix raises `unpred`=1. This includes a second prefix, which still executes as in R1.
- R8: `out_valid` is 1 exactly in the cycle after an `in_valid` cycle. While `out_valid` is 0, the signals `br_taken`, `lr_we`, `isa_switch`, `undef` and `unpred` are all 0.
- R9: During and right after reset, all outputs are 0 and the machine is in `ST_IDLE`.
- R10: Any other halfword (its bits [15:11] are none of 11110, 11111 or 11101) produces no branch, no LR write and no undef. All address sums wrap modulo 2^32.
- R11: `isa_switch` is only ever asserted together with `br_taken`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Halfword presented this cycle |
| instr | input | 16 | Instruction halfword |
| pc | input | 32 | Pipeline PC (halfword address + 4) |
| lr_in | input | 32 | Current link register value |
| out_valid | output | 1 | Results below are valid |
| br_taken | output | 1 | Branch strobe |
| br_target | output | 32 | Branch destination |
| lr_we | output | 1 | Link register write strobe |
| lr_out | output | 32 | New link register value |
| isa_switch | output | 1 | Request to enter the 32-bit instruction set |
| undef | output | 1 | Undefined-instruction flag |
| unpred | output | 1 | Broken prefix/suffix pairing flag |

## Verification
Pairing detection and execution can fire in the same cycle. A lone suffix both branches and raises `unpred`, and a double prefix both writes LR and raises `unpred`. The undefined form can likewise coincide with `unpred` when it is issued without a prefix. The bench provokes these by drawing random halfword classes with no enforced order, so that unpaired suffixes, repeated prefixes and unpaired undefined forms occur, and it adds directed sequences for each case. A bench model computes every flag and value for each cycle independently, and each one is compared separately, so a coincidence that drops either effect is caught.

// File: rtl/sbl_pkg.sv
package sbl_pkg;
    typedef enum logic [0:0] {
        ST_IDLE,
        ST_PREFIX_SEEN
    } sbl_state_e;

    typedef enum logic [2:0] {
        HW_PREFIX,
        HW_SUFFIX_STAY,
        HW_SUFFIX_SWITCH,
        HW_SUFFIX_UNDEF,
        HW_OTHER
    } hw_class_e;

    localparam int TAG_W = 5;
    localparam logic [TAG_W-1:0] TAG_PREFIX = 5'b11110;
    localparam logic [TAG_W-1:0] TAG_STAY   = 5'b11111;
    localparam logic [TAG_W-1:0] TAG_SWITCH = 5'b11101;
endpackage

// File: rtl/sbl_decode.sv
module sbl_decode
    import sbl_pkg::*;
#(
    parameter int HW_W = 16
) (
    input  logic [HW_W-1:0]       instr,
    output hw_class_e             cls,
    output logic [HW_W-TAG_W-1:0] imm
);
    localparam int IMM_W = HW_W - TAG_W;

    logic [TAG_W-1:0] tag;

    assign tag = instr[HW_W-1:IMM_W];
    assign imm = instr[IMM_W-1:0];

    always_comb begin
        if (tag == TAG_PREFIX)
            cls = HW_PREFIX;
        else if (tag == TAG_STAY)
            cls = HW_SUFFIX_STAY;
        else if (tag == TAG_SWITCH)
            cls = instr[0] ? HW_SUFFIX_UNDEF : HW_SUFFIX_SWITCH;
        else
            cls = HW_OTHER;
    end
endmodule

// File: rtl/sbl_addr.sv
module sbl_addr #(
    parameter int ADDR_W   = 32,
    parameter int IMM_W    = 11,
    parameter int HI_SHIFT = 12
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] lr_in,
    input  logic [IMM_W-1:0]  imm,
    output logic [ADDR_W-1:0] prefix_lr,
    output logic [ADDR_W-1:0] stay_target,
    output logic [ADDR_W-1:0] switch_target,
    output logic [ADDR_W-1:0] ret_addr
);
    localparam int EXT_W = ADDR_W - IMM_W;

    logic [ADDR_W-1:0] imm_sx;
    logic [ADDR_W-1:0] imm_zx;
    logic [ADDR_W-1:0] imm_hi_zx;
    logic [ADDR_W-1:0] lr_aligned;

    assign imm_sx     = {{EXT_W{imm[IMM_W-1]}}, imm};
    assign imm_zx     = {{EXT_W{1'b0}}, imm};
    assign imm_hi_zx  = {{(EXT_W + 1){1'b0}}, imm[IMM_W-1:1]};
    assign lr_aligned = {lr_in[ADDR_W-1:2], 2'b00};

    assign prefix_lr     = pc + (imm_sx << HI_SHIFT);
    assign stay_target   = lr_in + (imm_zx << 1);
    assign switch_target = lr_aligned + (imm_hi_zx << 2);
    assign ret_addr      = pc - ADDR_W'(2);
endmodule

// File: rtl/split_branch_link.sv
module split_branch_link
    import sbl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int HW_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [HW_W-1:0]   instr,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] lr_in,
    output logic              out_valid,
    output logic              br_taken,
    output logic [ADDR_W-1:0] br_target,
    output logic              lr_we,
    output logic [ADDR_W-1:0] lr_out,
    output logic              isa_switch,
    output logic              undef,
    output logic              unpred
);
    localparam int IMM_W = HW_W - TAG_W;

    sbl_state_e        state_q, state_d;
    hw_class_e         cls;
    logic [IMM_W-1:0]  imm;
    logic [ADDR_W-1:0] prefix_lr, stay_target, switch_target, ret_addr;
    logic              pair_ok;

    sbl_decode #(.HW_W(HW_W)) u_decode (
        .instr (instr),
        .cls   (cls),
        .imm   (imm)
    );

    sbl_addr #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .HI_SHIFT(12)) u_addr (
        .pc            (pc),
        .lr_in         (lr_in),
        .imm           (imm),
        .prefix_lr     (prefix_lr),
        .stay_target   (stay_target),
        .switch_target (switch_target),
        .ret_addr      (ret_addr)
    );

    assign pair_ok = (state_q == ST_PREFIX_SEEN);

    // Next state: a valid prefix arms the pairing, any other valid halfword disarms it
    always_comb begin
        state_d = state_q;
        if (in_valid)
            state_d = (cls == HW_PREFIX) ? ST_PREFIX_SEEN : ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            br_taken   <= 1'b0;
            br_target  <= '0;
            lr_we      <= 1'b0;
            lr_out     <= '0;
            isa_switch <= 1'b0;
            undef      <= 1'b0;
            unpred     <= 1'b0;
        end else begin
            out_valid  <= in_valid;
            br_taken   <= 1'b0;
            br_target  <= '0;
            lr_we      <= 1'b0;
            lr_out     <= '0;
            isa_switch <= 1'b0;
            undef      <= 1'b0;
            unpred     <= 1'b0;
            if (in_valid) begin
                unique case (cls)
                    HW_PREFIX: begin
                        lr_we  <= 1'b1;
                        lr_out <= prefix_lr;
                        unpred <= pair_ok;
                    end
                    HW_SUFFIX_STAY: begin
                        br_taken  <= 1'b1;
                        br_target <= stay_target;
                        lr_we     <= 1'b1;
                        lr_out    <= {ret_addr[ADDR_W-1:1], 1'b1};
                        unpred    <= !pair_ok;
                    end
                    HW_SUFFIX_SWITCH: begin
                        br_taken   <= 1'b1;
                        br_target  <= switch_target;
                        lr_we      <= 1'b1;
                        lr_out     <= ret_addr;
                        isa_switch <= 1'b1;
                        unpred     <= !pair_ok;
                    end
                    HW_SUFFIX_UNDEF: begin
                        undef  <= 1'b1;
                        unpred <= !pair_ok;
                    end
                    HW_OTHER: begin
                        unpred <= pair_ok;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R4: the undefined form neither branches nor writes LR
    p_undef_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        undef |-> (!br_taken && !lr_we && !isa_switch));

    // R11: a set switch is always part of a branch
    p_switch_with_branch_r11: assert property (@(posedge clk) disable iff (!rst_n)
        isa_switch |-> br_taken);

    // R3: a switching branch lands on a word boundary
    p_switch_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        isa_switch |-> (br_target[1:0] == 2'b00));

    // R5: a branch that stays in the compressed set leaves LR bit 0 set
    p_stay_lr_bit0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (br_taken && !isa_switch) |-> lr_out[0]);

    // R8: one-cycle latency from input strobe to output strobe
    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_quiet_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(br_taken || lr_we || isa_switch || undef || unpred));

    // R7: a prefix that follows a prefix is reported
    p_double_prefix_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cls == HW_PREFIX && state_q == ST_PREFIX_SEEN) |=> unpred);
endmodule

// File: tb/split_branch_link_test.sv
module split_branch_link_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] instr = '0;
    logic [31:0] pc = '0;
    logic [31:0] lr_in = '0;
    logic        out_valid, br_taken, lr_we, isa_switch, undef, unpred;
    logic [31:0] br_target, lr_out;

    int checks = 0;
    int failures = 0;
    bit mdl_prefix = 1'b0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    split_branch_link uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .pc(pc), .lr_in(lr_in), .out_valid(out_valid), .br_taken(br_taken),
        .br_target(br_target), .lr_we(lr_we), .lr_out(lr_out),
        .isa_switch(isa_switch), .undef(undef), .unpred(unpred)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] f_prefix_lr(input logic [31:0] p, input logic [10:0] im);
        logic [31:0] sx = {{21{im[10]}}, im};
        return p + (sx << 12);
    endfunction

    function automatic logic [31:0] f_stay_tgt(input logic [31:0] l, input logic [10:0] im);
        return l + {20'd0, im, 1'b0};
    endfunction

    function automatic logic [31:0] f_switch_tgt(input logic [31:0] l, input logic [9:0] im);
        return {l[31:2], 2'b00} + {20'd0, im, 2'b00};
    endfunction

    task automatic run_hw(input logic [15:0] hw, input logic [31:0] p, input logic [31:0] l);
        logic e_br = 0, e_we = 0, e_sw = 0, e_ud = 0, e_up = 0, nxt_prefix = 0;
        logic [31:0] e_tgt = '0, e_lr = '0;
        string tag = "R10";
        unique case (hw[15:11])
            5'b11110: begin
                tag = "R1"; e_we = 1; e_lr = f_prefix_lr(p, hw[10:0]);
                e_up = mdl_prefix; nxt_prefix = 1;
            end
            5'b11111: begin
                tag = "R2"; e_br = 1; e_tgt = f_stay_tgt(l, hw[10:0]);
                e_we = 1; e_lr = (p - 32'd2) | 32'd1; e_up = !mdl_prefix;
            end
            5'b11101: begin
                if (hw[0]) begin
                    tag = "R4"; e_ud = 1;
                end else begin
                    tag = "R3"; e_br = 1; e_sw = 1; e_tgt = f_switch_tgt(l, hw[10:1]);
                    e_we = 1; e_lr = p - 32'd2;
                end
                e_up = !mdl_prefix;
            end
            default: e_up = mdl_prefix;
        endcase
        @(negedge clk);
        instr = hw; pc = p; lr_in = l; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8", "out_valid", 32'(out_valid), 32'(1'b1));
        chk(tag, "br_taken", 32'(br_taken), 32'(e_br));
        if (e_br) chk(tag, "br_target", br_target, e_tgt);
        chk(tag, "lr_we", 32'(lr_we), 32'(e_we));
        if (e_we) chk((tag == "R1") ? "R1" : "R5", "lr_out", lr_out, e_lr);
        chk((tag == "R3") ? "R3" : "R11", "isa_switch", 32'(isa_switch), 32'(e_sw));
        chk("R4", "undef", 32'(undef), 32'(e_ud));
        chk((hw[15:11] == 5'b11111 || hw[15:11] == 5'b11101) ? "R6" : "R7",
            "unpred", 32'(unpred), 32'(e_up));
        mdl_prefix = nxt_prefix;
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9", "out_valid in reset", 32'(out_valid), 32'd0);
        chk("R9", "lr_out in reset", lr_out, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "flags after reset", 32'({br_taken, lr_we, isa_switch, undef, unpred}), 32'd0);

        // Directed: proper stay pair, negative high offset
        run_hw(16'hF7FF, 32'h0000_1004, 32'h0);
        run_hw(16'hF801, 32'h0000_1006, 32'h0000_0404);
        // Directed: proper switch pair with unaligned LR
        run_hw(16'hF000, 32'h0000_2004, 32'h0);
        run_hw({5'b11101, 10'h155, 1'b0}, 32'h0000_2006, 32'h0000_2007);
        // R8: idle cycle gives no output
        @(negedge clk);
        chk("R8", "out_valid idle", 32'(out_valid), 32'd0);
        // R6: lone suffix still executes
        run_hw(16'hF8FF, 32'h0000_3000, 32'h0000_5000);
        // R4: undef with and without prefix
        run_hw({5'b11101, 10'h3FF, 1'b1}, 32'h10, 32'h20);
        run_hw(16'hF001, 32'h0000_4004, 32'h0);
        run_hw({5'b11101, 10'h001, 1'b1}, 32'h0000_4006, 32'h0000_5004);
        // R7: double prefix, prefix then other halfword
        run_hw(16'hF123, 32'h100, 32'h0);
        run_hw(16'hF456, 32'h102, 32'h0);
        run_hw(16'h4600, 32'h104, 32'h0);
        // R10: wrap-around
        run_hw(16'hF000, 32'hFFFF_FFFC, 32'h0);
        run_hw(16'hFFFF, 32'hFFFF_FFFE, 32'hFFFF_FFF0);
        run_hw(16'h1234, 32'h8, 32'h8);

        // Constrained random
        for (int i = 0; i < 400; i++) begin
            logic [15:0] hw = 16'($urandom);
            int k = int'($urandom % 5);
            if (k == 0 || k == 1) hw[15:11] = 5'b11110;
            else if (k == 2) hw[15:11] = 5'b11111;
            else if (k == 3) hw[15:11] = 5'b11101;
            run_hw(hw, $urandom, $urandom);
        end

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule